// File: doc/BRIEF.md
# Descriptor Ring Index Register Bank

This block holds the control registers a device keeps for a set of host descriptor rings. Each ring has a 64-bit base address, an entry count, a head index that the host owns and a tail index that the device owns. It also has a write-only control word, a credit word and one spare read/write word. The host reaches all of these through a plain 32-bit register port. Writes take effect at the clock edge, and reads return data combinationally from the address.

The device side has one completion strobe per ring. A strobe moves that ring's tail forward by one entry, but only when the ring holds work. The host posts work by moving the head forward. A head write that would overtake the tail is refused and leaves a sticky error flag set. Writing the base, writing a legal size, or setting the reset bit in the control word all return head and tail to zero. Per-ring empty, full and error flags are brought out as status outputs.

Top module: `desc_ring_bank`

## Requirements
- R1: After reset every ring has base 0, size 2, head 0, tail 0, credits 0, spare 0, empty asserted, full deasserted and the error flag clear.
- R2: Ring r decodes at byte address 0x1000 + 32*r. Its words are at these offsets: base low 0x00, base high 0x04, size 0x08, head 0x0C, tail 0x10, control 0x14, credits 0x18, spare 0x1C. Credits and spare read back what was last written, and the control word reads as 0.
- R3: A size write is accepted only if the value is a power of two from 2 to 65536. Any other value leaves size, head and tail unchanged.
- R4: A write to either base word, or an accepted size write, sets head and tail to 0 at the same edge.
- R5: The base is 8-byte aligned: bits [2:0] of the base low word always read as 0, whatever was written.
- R6: A ring reports empty when head equals tail. It reports full when (head+1) mod size equals tail.
- R7: A head write of value v is accepted only if v < size and (v - tail) mod size >= (head - tail) mod size. A refused write leaves head unchanged and sets that ring's sticky error flag.
- R8: A completion strobe on a non-empty ring sets tail to (tail+1) mod size. A strobe on an empty ring changes nothing.
- R9: Writing the control word with bit 0 set clears head, tail and the error flag. Writing it with bit 0 clear has no effect.
- R10: Reads of addresses below 0x1000, of rings beyond the configured count, or of non-word-aligned addresses return 0. Writes to them, and writes to the tail word, change nothing.
- R11: When a clearing write and a completion strobe hit the same ring in the same cycle, head and tail both end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 13 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| ring_done | input | NUM_RINGS | Per-ring completion strobe from the device |
| ring_empty | output | NUM_RINGS | Per-ring empty flag |
| ring_full | output | NUM_RINGS | Per-ring full flag |
| head_err | output | NUM_RINGS | Per-ring sticky refused-head-write flag |

## Verification
The hardest state to reach is a full ring whose head has wrapped below its tail. In that state a head write with a small value can either be a legal advance or an illegal lap, and the only thing that separates them is the modular distance from the tail. To get there, the stimulus shrinks a ring to eight entries, drains two entries with completion strobes, and then posts head values that wrap past the end of the ring. Pseudo-random phases then mix head writes, strobes and clearing writes on small rings, so wrap, full, refusal and same-cycle clear-plus-strobe cases keep recurring.

// File: rtl/drb_pkg.sv
package drb_pkg;

    typedef enum logic [3:0] {
        FLD_NONE,
        FLD_BASE_LO,
        FLD_BASE_HI,
        FLD_SIZE,
        FLD_HEAD,
        FLD_TAIL,
        FLD_CTRL,
        FLD_CRED,
        FLD_SPARE
    } field_e;

    localparam int WIN_BITS  = 5;
    localparam int RIDX_BITS = 7;

endpackage

// File: rtl/drb_decode.sv
module drb_decode #(
    parameter int NUM_RINGS = 4
) (
    input  logic [12:0]                       addr_i,
    output logic                              hit_o,
    output logic [drb_pkg::RIDX_BITS-1:0]     ring_o,
    output drb_pkg::field_e                   field_o
);
    import drb_pkg::*;

    always_comb begin
        ring_o  = addr_i[11:WIN_BITS];
        hit_o   = addr_i[12] && (int'(ring_o) < NUM_RINGS) && (addr_i[1:0] == 2'b00);
        field_o = FLD_NONE;
        if (hit_o) begin
            case (addr_i[4:2])
                3'd0:    field_o = FLD_BASE_LO;
                3'd1:    field_o = FLD_BASE_HI;
                3'd2:    field_o = FLD_SIZE;
                3'd3:    field_o = FLD_HEAD;
                3'd4:    field_o = FLD_TAIL;
                3'd5:    field_o = FLD_CTRL;
                3'd6:    field_o = FLD_CRED;
                default: field_o = FLD_SPARE;
            endcase
        end
    end

endmodule

// File: rtl/drb_ring.sv
module drb_ring #(
    parameter int IDX_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  drb_pkg::field_e      field_i,
    input  logic [31:0]          wdata_i,
    input  logic                 complete_i,
    output logic [63:0]          base_o,
    output logic [IDX_W:0]       size_o,
    output logic [IDX_W-1:0]     head_o,
    output logic [IDX_W-1:0]     tail_o,
    output logic [31:0]          credits_o,
    output logic [31:0]          spare_o,
    output logic                 empty_o,
    output logic                 full_o,
    output logic                 err_o
);
    import drb_pkg::*;

    typedef struct packed {
        logic [63:0]      base;
        logic [IDX_W:0]   size;
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [31:0]      cred;
        logic [31:0]      spare;
        logic             err;
    } ring_st_t;

    ring_st_t s_d, s_q;

    logic [IDX_W-1:0] mask_idx;
    logic [IDX_W-1:0] head_inc;
    logic [IDX_W-1:0] tail_inc;
    logic [IDX_W-1:0] dist_new;
    logic [IDX_W-1:0] dist_old;
    logic             size_ok;
    logic             head_ok;
    logic             clear;

    always_comb begin
        s_d      = s_q;
        mask_idx = IDX_W'(s_q.size - 1'b1);
        head_inc = (s_q.head + 1'b1) & mask_idx;
        tail_inc = (s_q.tail + 1'b1) & mask_idx;
        empty_o  = (s_q.head == s_q.tail);
        full_o   = (head_inc == s_q.tail);

        size_ok  = (wdata_i[31:IDX_W+1] == '0) && ($countones(wdata_i) == 1) && !wdata_i[0];
        dist_new = (wdata_i[IDX_W-1:0] - s_q.tail) & mask_idx;
        dist_old = (s_q.head - s_q.tail) & mask_idx;
        head_ok  = (wdata_i[31:IDX_W+1] == '0) && (wdata_i[IDX_W:0] < s_q.size)
                   && (dist_new >= dist_old);

        clear = wr_en_i && ((field_i == FLD_BASE_LO) || (field_i == FLD_BASE_HI)
                || ((field_i == FLD_SIZE) && size_ok) || ((field_i == FLD_CTRL) && wdata_i[0]));

        if (complete_i && !empty_o) begin
            s_d.tail = tail_inc;
        end

        if (wr_en_i) begin
            case (field_i)
                FLD_BASE_LO: s_d.base[31:0]  = {wdata_i[31:3], 3'b000};
                FLD_BASE_HI: s_d.base[63:32] = wdata_i;
                FLD_SIZE:    if (size_ok) s_d.size = wdata_i[IDX_W:0];
                FLD_HEAD: begin
                    if (head_ok) s_d.head = wdata_i[IDX_W-1:0];
                    else         s_d.err  = 1'b1;
                end
                FLD_CTRL:    if (wdata_i[0]) s_d.err = 1'b0;
                FLD_CRED:    s_d.cred  = wdata_i;
                FLD_SPARE:   s_d.spare = wdata_i;
                default:     ;
            endcase
        end

        if (clear) begin
            s_d.head = '0;
            s_d.tail = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.size <= (IDX_W+1)'(2);
        end else begin
            s_q <= s_d;
        end
    end

    assign base_o    = s_q.base;
    assign size_o    = s_q.size;
    assign head_o    = s_q.head;
    assign tail_o    = s_q.tail;
    assign credits_o = s_q.cred;
    assign spare_o   = s_q.spare;
    assign err_o     = s_q.err;

    a_r3_size_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(s_q.size) == 1) && !s_q.size[0]);

    a_r7_head_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (IDX_W+1)'(s_q.head) < s_q.size);

    a_r7_reject_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $stable(head_o));

    a_r8_empty_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (complete_i && empty_o && !wr_en_i) |=> $stable(tail_o));

    a_r8_tail_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!complete_i && !wr_en_i) |=> $stable(tail_o));

    a_r6_never_empty_and_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));

endmodule

// File: rtl/desc_ring_bank.sv
module desc_ring_bank #(
    parameter int NUM_RINGS = 4,
    parameter int IDX_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [12:0]          host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata,
    input  logic [NUM_RINGS-1:0] ring_done,
    output logic [NUM_RINGS-1:0] ring_empty,
    output logic [NUM_RINGS-1:0] ring_full,
    output logic [NUM_RINGS-1:0] head_err
);
    import drb_pkg::*;

    logic                  dec_hit;
    logic [RIDX_BITS-1:0]  dec_ring;
    field_e                dec_field;

    logic [63:0]      base_a  [NUM_RINGS];
    logic [IDX_W:0]   size_a  [NUM_RINGS];
    logic [IDX_W-1:0] head_a  [NUM_RINGS];
    logic [IDX_W-1:0] tail_a  [NUM_RINGS];
    logic [31:0]      cred_a  [NUM_RINGS];
    logic [31:0]      spare_a [NUM_RINGS];

    drb_decode #(.NUM_RINGS(NUM_RINGS)) u_dec (
        .addr_i  (host_addr),
        .hit_o   (dec_hit),
        .ring_o  (dec_ring),
        .field_o (dec_field)
    );

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        localparam logic [RIDX_BITS-1:0] RID = RIDX_BITS'(g);
        logic sel_wr;
        assign sel_wr = host_wr && dec_hit && (dec_ring == RID);

        drb_ring #(.IDX_W(IDX_W)) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (sel_wr),
            .field_i    (dec_field),
            .wdata_i    (host_wdata),
            .complete_i (ring_done[g]),
            .base_o     (base_a[g]),
            .size_o     (size_a[g]),
            .head_o     (head_a[g]),
            .tail_o     (tail_a[g]),
            .credits_o  (cred_a[g]),
            .spare_o    (spare_a[g]),
            .empty_o    (ring_empty[g]),
            .full_o     (ring_full[g]),
            .err_o      (head_err[g])
        );
    end

    always_comb begin
        host_rdata = '0;
        for (int r = 0; r < NUM_RINGS; r++) begin
            if (dec_hit && (dec_ring == RIDX_BITS'(r))) begin
                case (dec_field)
                    FLD_BASE_LO: host_rdata = base_a[r][31:0];
                    FLD_BASE_HI: host_rdata = base_a[r][63:32];
                    FLD_SIZE:    host_rdata = 32'(size_a[r]);
                    FLD_HEAD:    host_rdata = 32'(head_a[r]);
                    FLD_TAIL:    host_rdata = 32'(tail_a[r]);
                    FLD_CRED:    host_rdata = cred_a[r];
                    FLD_SPARE:   host_rdata = spare_a[r];
                    default:     host_rdata = '0;
                endcase
            end
        end
    end

    a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (host_rdata == '0));

    a_r2_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_field == FLD_CTRL) |-> (host_rdata == '0));

endmodule

// File: tb/desc_ring_bank_test.sv
module desc_ring_bank_test;
    localparam int NR = 4;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_wr;
    logic [12:0]   host_addr;
    logic [31:0]   host_wdata;
    logic [31:0]   host_rdata;
    logic [NR-1:0] ring_done;
    logic [NR-1:0] ring_empty;
    logic [NR-1:0] ring_full;
    logic [NR-1:0] head_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    longint mbase [NR];
    longint msize [NR];
    longint mhead [NR];
    longint mtail [NR];
    longint mcred [NR];
    longint mspare[NR];
    bit     merr  [NR];

    always #5 clk = ~clk;

    desc_ring_bank #(.NUM_RINGS(NR), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ring_done(ring_done),
        .ring_empty(ring_empty), .ring_full(ring_full), .head_err(head_err)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit size_valid(input longint w);
        return (w >= 2) && (w <= 65536) && ((w & (w - 1)) == 0);
    endfunction

    function automatic longint modd(input longint a, input longint m);
        return ((a % m) + m) % m;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < NR; r++) begin
            mbase[r] = 0; msize[r] = 2; mhead[r] = 0; mtail[r] = 0;
            mcred[r] = 0; mspare[r] = 0; merr[r] = 0;
        end
    endtask

    task automatic model_apply(input bit we, input longint a, input longint wd, input logic [NR-1:0] dn);
        for (int r = 0; r < NR; r++) begin
            bit hit, clr;
            longint off, nt;
            hit = we && (a >= 'h1000) && (((a - 'h1000) >> 5) == r) && ((a & 3) == 0);
            off = a & 31;
            clr = 0;
            nt  = mtail[r];
            if (dn[r] && (mhead[r] != mtail[r])) nt = (mtail[r] + 1) % msize[r];
            if (hit) begin
                case (off)
                    'h00: begin mbase[r] = (mbase[r] & 64'hFFFF_FFFF_0000_0000) | (wd & 'hFFFF_FFF8); clr = 1; end
                    'h04: begin mbase[r] = (mbase[r] & 64'h0000_0000_FFFF_FFFF) | (wd << 32); clr = 1; end
                    'h08: if (size_valid(wd)) begin msize[r] = wd; clr = 1; end
                    'h0C: begin
                        if (wd < msize[r] && modd(wd - mtail[r], msize[r]) >= modd(mhead[r] - mtail[r], msize[r]))
                            mhead[r] = wd;
                        else
                            merr[r] = 1;
                    end
                    'h14: if (wd & 1) begin clr = 1; merr[r] = 0; end
                    'h18: mcred[r] = wd;
                    'h1C: mspare[r] = wd;
                    default: ;
                endcase
            end
            mtail[r] = nt;
            if (clr) begin mhead[r] = 0; mtail[r] = 0; end
        end
    endtask

    function automatic longint exp_read(input longint a);
        longint r;
        if (a < 'h1000 || (a & 3) != 0) return 0;
        r = (a - 'h1000) >> 5;
        if (r >= NR) return 0;
        case (a & 31)
            'h00: return mbase[r] & 'hFFFF_FFFF;
            'h04: return (mbase[r] >> 32) & 'hFFFF_FFFF;
            'h08: return msize[r];
            'h0C: return mhead[r];
            'h10: return mtail[r];
            'h18: return mcred[r];
            'h1C: return mspare[r];
            default: return 0;
        endcase
    endfunction

    task automatic cmp_status(input string tag);
        logic [NR-1:0] e, f, x;
        for (int r = 0; r < NR; r++) begin
            e[r] = (mhead[r] == mtail[r]);
            f[r] = (((mhead[r] + 1) % msize[r]) == mtail[r]);
            x[r] = merr[r];
        end
        chk({tag, " R6 empty"}, ring_empty, e);
        chk({tag, " R6 full"}, ring_full, f);
        chk({tag, " R7 err"}, head_err, x);
    endtask

    task automatic cyc(input string tag, input bit we, input logic [12:0] a,
                       input logic [31:0] d, input logic [NR-1:0] dn);
        host_wr = we; host_addr = a; host_wdata = d; ring_done = dn;
        model_apply(we, longint'(a), longint'(d), dn);
        @(posedge clk);
        #1;
        host_wr = 1'b0; ring_done = '0;
        cmp_status(tag);
    endtask

    task automatic wr(input string tag, input int a, input longint d);
        cyc(tag, 1'b1, 13'(a), 32'(d), '0);
    endtask

    task automatic rd(input string tag, input int a);
        host_addr = 13'(a);
        #1;
        chk(tag, longint'(host_rdata), exp_read(longint'(a)));
    endtask

    task automatic rd_ring(input string tag, input int r);
        for (int o = 0; o < 32; o += 4) rd(tag, 'h1000 + 32 * r + o);
    endtask

    function automatic int ra(input int r, input int o);
        return 'h1000 + 32 * r + o;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0; ring_done = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_status("R1 reset");
        for (int r = 0; r < NR; r++) rd_ring("R1 reset regs", r);

        // R2 R5: map, base alignment, credits and spare storage
        wr("R5 base lo", ra(0, 'h00), 'h1234_5677);
        wr("R4 base hi", ra(0, 'h04), 'hABCD_0001);
        rd("R5 base lo low bits zero", ra(0, 'h00));
        rd("R2 base hi", ra(0, 'h04));
        wr("R2 credits", ra(1, 'h18), 'hCAFE_0007);
        wr("R2 spare", ra(2, 'h1C), 'h5A5A_A5A5);
        rd("R2 credits read", ra(1, 'h18));
        rd("R2 spare read", ra(2, 'h1C));
        rd("R2 ctrl reads zero", ra(0, 'h14));

        // R7 R8 R6: wrap to full on an 8-entry ring
        wr("R3 size 8", ra(0, 'h08), 8);
        wr("R7 head 5", ra(0, 'h0C), 5);
        cyc("R8 complete", 1'b0, '0, '0, 4'b0001);
        cyc("R8 complete", 1'b0, '0, '0, 4'b0001);
        wr("R7 head 7", ra(0, 'h0C), 7);
        wr("R7 head wrap 1 full", ra(0, 'h0C), 1);
        chk("R6 ring0 full", ring_full[0], 1);
        rd("R7 head after wrap", ra(0, 'h0C));
        wr("R7 head lap refused", ra(0, 'h0C), 2);
        wr("R7 head out of range", ra(0, 'h0C), 9);
        rd("R7 head unchanged", ra(0, 'h0C));
        rd("R8 tail", ra(0, 'h10));
        chk("R7 sticky err", head_err[0], 1);
        repeat (6) cyc("R8 drain", 1'b0, '0, '0, 4'b0001);
        cyc("R8 empty strobe ignored", 1'b0, '0, '0, 4'b0011);
        rd("R8 tail after drain", ra(0, 'h10));
        rd("R8 ring1 tail", ra(1, 'h10));

        // R9: control
        wr("R9 ctrl bit0 clear no effect", ra(0, 'h14), 'hFFFF_FFFE);
        chk("R9 err kept", head_err[0], 1);
        wr("R9 ctrl reset", ra(0, 'h14), 1);
        rd_ring("R9 after ctrl", 0);

        // R3 R4: size validation
        wr("R7 head 1 on ring2", ra(2, 'h0C), 1);
        wr("R3 size 3", ra(2, 'h08), 3);
        wr("R3 size 0", ra(2, 'h08), 0);
        wr("R3 size 1", ra(2, 'h08), 1);
        wr("R3 size 131072", ra(2, 'h08), 131072);
        rd_ring("R3 invalid ignored", 2);
        wr("R3 size 65536", ra(2, 'h08), 65536);
        rd_ring("R4 size clears", 2);
        wr("R7 head 65535", ra(2, 'h0C), 65535);
        cyc("R8 complete big", 1'b0, '0, '0, 4'b0100);
        rd("R8 tail big", ra(2, 'h10));
        wr("R4 base hi clears", ra(2, 'h04), 3);
        rd_ring("R4 after base", 2);

        // R11: clear and strobe in the same cycle
        wr("R3 size 4 ring3", ra(3, 'h08), 4);
        wr("R7 head 3 ring3", ra(3, 'h0C), 3);
        cyc("R11 ctrl with strobe", 1'b1, 13'(ra(3, 'h14)), 1, 4'b1000);
        rd_ring("R11 result", 3);
        wr("R7 head 2 ring3", ra(3, 'h0C), 2);
        cyc("R11 base with strobe", 1'b1, 13'(ra(3, 'h00)), 'h40, 4'b1000);
        rd_ring("R11 base result", 3);

        // R10: unmapped and ignored accesses
        wr("R10 tail write", ra(1, 'h10), 5);
        wr("R10 low write", 'h0010, 'h1234);
        wr("R10 ring beyond", ra(NR, 'h0C), 1);
        wr("R10 misaligned", ra(1, 'h0D), 1);
        rd("R10 low read", 'h0000);
        rd("R10 beyond read", ra(NR, 'h08));
        rd("R10 misaligned read", ra(1, 'h09));
        rd_ring("R10 ring1 intact", 1);

        // mixed pseudo-random phase
        wr("R3 size 4 ring1", ra(1, 'h08), 4);
        wr("R3 size 8 ring3", ra(3, 'h08), 8);
        seed = 32'h1ACE_B00C;
        for (int i = 0; i < 600; i++) begin
            int rr, op, v;
            seed = seed * 1103515245 + 12345;
            rr = (seed >>> 16) & 3;
            op = (seed >>> 20) & 15;
            v  = (seed >>> 24) & 15;
            if (op < 7)
                cyc("R7 rand head", 1'b1, 13'(ra(rr, 'h0C)), 32'(v % 10), 4'((seed >>> 8) & 15));
            else if (op == 7)
                cyc("R9 rand ctrl", 1'b1, 13'(ra(rr, 'h14)), 32'(v & 1), 4'((seed >>> 8) & 15));
            else if (op == 8)
                cyc("R3 rand size", 1'b1, 13'(ra(rr, 'h08)), 32'(v), 4'((seed >>> 8) & 15));
            else
                cyc("R8 rand strobe", 1'b0, '0, '0, 4'((seed >>> 8) & 15));
            if ((i % 50) == 0) rd_ring("R8 rand regs", rr);
        end
        for (int r = 0; r < NR; r++) rd_ring("R6 final regs", r);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule